// File: doc/BRIEF.md
# Signed Integer ALU

A purely combinational arithmetic and logic unit for a small 32-bit integer datapath. A 4-bit operation select chooses one of fourteen functions on two signed operands `a` and `b`, and the unit drives one signed result. The functions are add, subtract, multiply, divide, three shifts, three bitwise operations and four comparisons. Each comparison writes 0 or 1 into the full-width result.

The surrounding datapath decodes instructions into the operation select. It then reads `y` in the same cycle. There is no clock, no reset and no state. Multiply and divide complete in a single combinational pass. Flags, remainder and the upper half of the product are not produced.

Top module: `alu32`

## Requirements
- R1: Select 0010 gives a+b and select 0110 gives a-b, both wrapping modulo 2^32.
- R2: Select 0111 gives the low 32 bits of the signed product a*b.
- R3: Select 1111 gives the signed quotient a/b, truncated toward zero, when b is nonzero and the pair is not (most negative, -1).
- R4: Select 1111 with b equal to zero gives all ones (-1).
- R5: Select 1111 with a equal to the most negative value and b equal to -1 gives the most negative value.
- R6: Shift amounts are taken from b[4:0] only, and the upper 27 bits of b have no effect. Select 0100 shifts a left and fills with zeros.
- R7: Select 1100 shifts a right and fills with zeros. Select 1110 shifts a right and fills with copies of a[31].
- R8: Selects 0000, 0001 and 0011 give bitwise AND, OR and XOR of a and b.
- R9: Select 1000 (equal) and select 1001 (not equal) give 1 when their condition holds and 0 otherwise.
- R10: Select 1010 gives 1 when a<b and 0 otherwise. Select 1011 gives 1 when a>=b and 0 otherwise. Both compare a and b as two's-complement values.
- R11: The unused selects 0101 and 1101 give a result of zero.
- R12: The result depends only on the present select and operands. Applying the same inputs again gives the same result, whatever was applied in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op | input | 4 | Operation select |
| a | input | 32 | First operand, signed |
| b | input | 32 | Second operand or shift amount, signed |
| y | output | 32 | Result, signed |

## Verification
The bound checker watches every input change for the properties that hold in isolation:
- comparison results stay 0 or 1;
- the unused selects give zero;
- the divide-by-zero and most-negative-over-minus-one results are correct;
- logical right shifts by a nonzero amount clear the sign bit;
- arithmetic right shifts keep it.

Exact arithmetic values need the bench's independent model and its sweep over every select and a grid of positive, negative and extreme operand pairs. That covers correct products, truncated quotients, shift-amount masking and the signed ordering of mixed-sign operands. Only a replay of earlier vectors after a full sweep shows that the unit holds no state.

// File: rtl/alu32.sv
module alu32 #(
  parameter int W = 32
) (
  input  logic [3:0]         op,
  input  logic signed [W-1:0] a,
  input  logic signed [W-1:0] b,
  output logic signed [W-1:0] y
);
  localparam int SHW = $clog2(W);
  localparam logic signed [W-1:0] MIN_V = {1'b1, {(W-1){1'b0}}};
  localparam logic signed [W-1:0] ALL_ONES = '1;

  localparam logic [3:0] OP_AND = 4'b0000, OP_OR  = 4'b0001, OP_ADD = 4'b0010,
                         OP_XOR = 4'b0011, OP_SLL = 4'b0100, OP_SUB = 4'b0110,
                         OP_MUL = 4'b0111, OP_EQ  = 4'b1000, OP_NE  = 4'b1001,
                         OP_LT  = 4'b1010, OP_GE  = 4'b1011, OP_SRL = 4'b1100,
                         OP_SRA = 4'b1110, OP_DIV = 4'b1111;

  logic [SHW-1:0] sh;
  logic           lt_s;
  logic signed [W-1:0] quo;

  assign sh   = b[SHW-1:0];
  assign lt_s = a < b;

  always_comb begin
    if (b == '0)                      quo = ALL_ONES;
    else if (a == MIN_V && b == ALL_ONES) quo = MIN_V;
    else                              quo = a / b;
  end

  always_comb begin
    case (op)
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_MUL:  y = a * b;
      OP_DIV:  y = quo;
      OP_SLL:  y = a << sh;
      OP_SRL:  y = $signed($unsigned(a) >> sh);
      OP_SRA:  y = a >>> sh;
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      OP_EQ:   y = {{(W-1){1'b0}}, a == b};
      OP_NE:   y = {{(W-1){1'b0}}, a != b};
      OP_LT:   y = {{(W-1){1'b0}}, lt_s};
      OP_GE:   y = {{(W-1){1'b0}}, ~lt_s};
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/alu32_chk.sv
module alu32_chk #(
  parameter int W = 32
) (
  input logic [3:0]          op,
  input logic signed [W-1:0] a,
  input logic signed [W-1:0] b,
  input logic signed [W-1:0] y
);
  localparam logic signed [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
  localparam int SB = $clog2(W);

  always_comb begin
    // R9
    cmp_bool_chk: assert (op[3:2] != 2'b10 || y[W-1:1] == '0);
    // R11
    unused_zero_chk: assert (!(op == 4'b0101 || op == 4'b1101) || y == '0);
    // R4
    div_zero_chk: assert (!(op == 4'b1111 && b == '0) || y == -1);
    // R5
    div_ovf_chk: assert (!(op == 4'b1111 && a == MOST_NEG && b == -1) || y == MOST_NEG);
    // R7
    srl_fill_chk: assert (!(op == 4'b1100 && b[SB-1:0] != '0) || !y[W-1]);
    // R7
    sra_fill_chk: assert (op != 4'b1110 || y[W-1] == a[W-1]);
  end
endmodule

bind alu32 alu32_chk #(.W(W)) chk_i (.op(op), .a(a), .b(b), .y(y));

// File: tb/alu32_tb_top.sv
module alu32_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [3:0]         op = '0;
  logic signed [31:0] a  = '0;
  logic signed [31:0] b  = '0;
  logic signed [31:0] y;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  alu32 dut_i (.op(op), .a(a), .b(b), .y(y));

  localparam int NV = 16;
  logic signed [31:0] vals [NV];
  initial begin
    vals[0]  = 32'sd0;          vals[1]  = 32'sd1;
    vals[2]  = -32'sd1;         vals[3]  = 32'sd7;
    vals[4]  = -32'sd7;         vals[5]  = 32'sd100;
    vals[6]  = -32'sd3;         vals[7]  = 32'sd32;
    vals[8]  = 32'sd33;         vals[9]  = 32'h7fff_ffff;
    vals[10] = 32'h8000_0000;   vals[11] = 32'h1234_5678;
    vals[12] = -32'sd123456;    vals[13] = 32'sd65537;
    vals[14] = 32'h0000_0fe4;   vals[15] = 32'sd31;
  end

  function automatic logic signed [31:0] low32(longint v);
    return v[31:0];
  endfunction

  function automatic logic signed [31:0] model(logic [3:0] o, logic signed [31:0] x, logic signed [31:0] z);
    longint lx = x;
    longint lz = z;
    longint ux = longint'({32'd0, x});
    int     s  = int'(z & 32'sd31);
    longint p  = longint'(1) << s;
    longint mx, mz, q;
    case (o)
      4'b0010: return low32(lx + lz);
      4'b0110: return low32(lx - lz);
      4'b0111: return low32(lx * lz);
      4'b1111: begin
        if (lz == 0) return -32'sd1;
        mx = (lx < 0) ? -lx : lx;
        mz = (lz < 0) ? -lz : lz;
        q  = mx / mz;
        if ((lx < 0) != (lz < 0)) q = -q;
        return low32(q);
      end
      4'b0100: return low32(ux * p);
      4'b1100: return low32(ux / p);
      4'b1110: return low32((lx >= 0) ? lx / p : -((-lx + p - 1) / p));
      4'b0000: return x & z;
      4'b0001: return x | z;
      4'b0011: return x ^ z;
      4'b1000: return (lx == lz) ? 32'sd1 : 32'sd0;
      4'b1001: return (lx != lz) ? 32'sd1 : 32'sd0;
      4'b1010: return (lx < lz)  ? 32'sd1 : 32'sd0;
      4'b1011: return (lx >= lz) ? 32'sd1 : 32'sd0;
      default: return 32'sd0;
    endcase
  endfunction

  function automatic string req_of(logic [3:0] o, logic signed [31:0] x, logic signed [31:0] z);
    case (o)
      4'b0010, 4'b0110: return "R1";
      4'b0111: return "R2";
      4'b1111: return (z == 0) ? "R4" : ((x == 32'h8000_0000 && z == -1) ? "R5" : "R3");
      4'b0100: return "R6";
      4'b1100, 4'b1110: return "R7";
      4'b0000, 4'b0001, 4'b0011: return "R8";
      4'b1000, 4'b1001: return "R9";
      4'b1010, 4'b1011: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic apply_check(logic [3:0] o, logic signed [31:0] x, logic signed [31:0] z, string tag);
    logic signed [31:0] exp_v;
    @(negedge clk);
    op = o; a = x; b = z;
    exp_v = model(o, x, z);
    @(posedge clk);
    #1;
    n_chk++;
    if (y !== exp_v) begin
      n_bad++;
      $display("FAIL %s op=%b a=%0d b=%0d actual=%0d expected=%0d", tag, o, x, z, y, exp_v);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // Reset state: all-zero inputs (AND select) give zero, unused select R11
    apply_check(4'b0000, 32'sd0, 32'sd0, "R8");
    apply_check(4'b0101, 32'sd5, 32'sd9, "R11");
    // Full sweep over every select and operand pair
    for (int o = 0; o < 16; o++)
      for (int i = 0; i < NV; i++)
        for (int j = 0; j < NV; j++)
          apply_check(o[3:0], vals[i], vals[j], req_of(o[3:0], vals[i], vals[j]));
    // R6: upper bits of shift amount ignored
    apply_check(4'b0100, 32'sd5, 32'sh7fff_ffe3, "R6");
    apply_check(4'b1110, -32'sd1024, 32'sh0000_0124, "R7");
    // R3 truncation toward zero on mixed signs
    apply_check(4'b1111, -32'sd7, 32'sd2, "R3");
    apply_check(4'b1111, 32'sd7, -32'sd2, "R3");
    // R12: replay earlier vectors after unrelated activity
    apply_check(4'b0111, vals[11], vals[12], "R12");
    apply_check(4'b1010, vals[10], vals[9], "R12");
    apply_check(4'b0101, vals[9], vals[9], "R12");
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule